// File: doc/BRIEF.md
# Programmable Clock Divider Crosspoint

This block turns two source clocks into six output clocks. One source is the reference clock; the other is a VCO clock produced elsewhere. The PLL that produces the VCO clock is not part of this block. A bank of post dividers sits between the sources and the outputs. It holds two divide-by-2 taps, a divide-by-3 tap and a divide-by-4 tap, all fed from one shared source choice. It also holds two divide-by-N stages, each with its own 7-bit divisor and its own source choice. A crosspoint gives every output its own 3-bit selector. The selector picks one divider tap, the undivided reference, or a parked low level. An output can therefore run at VCO/div, REF/div or REF.

All logic runs on one fast core clock `clk`. The two sources come in as tick strobes. Each tick is a one-cycle pulse on `clk` that marks one edge, or half period, of that source clock. Every divided clock is rebuilt as a registered level, so all output edges line up with `clk`. Software sets up the block through an 8-bit address, 8-bit data write port.

Top module: `clk_xpt_div`

## Requirements
- R1: While `rst_n` is low, every `clk_out` bit is 0. After reset, every output selects the reference bypass, both divide-by-N divisors are 1, and every source choice is the reference.
- R2: Selector code 0 routes the reference to the output: a period of 2 reference ticks, high for 1 tick.
- R3: Selector codes 2 and 3 each pick their own divide-by-2 tap. Code 4 picks divide-by-3 and code 5 picks divide-by-4. A tap dividing by N has a period of 2N source ticks and is high for N of them.
- R4: Bit 0 at address 0x02 sets the source of the four fixed taps: 0 is the reference, 1 is the VCO.
- R5: Selector code 7 holds its output low.
- R6: Addresses 0x00 and 0x01 hold the divide-by-N stages reached through selector codes 1 and 6. In each, bit 7 picks the source (1 = VCO, 0 = reference) and bits 6:0 hold N. For N from 2 to 127 the period is 2N source ticks, high for N.
- R7: A divisor of 0 or 1 passes the stage's source through undivided.
- R8: A change to a divisor, a source or a selector takes effect only at the end of a full divided period. The output is parked low until the new tap starts a fresh period, so no high or low phase is shorter than one tick of the source it belongs to.
- R9: The output selectors live at addresses 0x08 to 0x0D, one per output in bits 2:0. A write with `wr_en` high lands on the next `clk` edge.
- R10: A write to any other address changes no setting. Aliases such as 0x80 are included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all state is registered on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe per reference clock edge |
| vco_tick | input | 1 | One-cycle strobe per VCO clock edge |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| clk_out | output | 6 | Rebuilt output clocks, one bit per output |

## Verification
The hard case is a switch that happens while a clock is running. In that case the old tap and the new tap are both part-way through a phase, so a careless handover would leave a short pulse. The stimulus reaches this case by writing selectors, divisors and source bits while every output is already toggling. The reference and VCO tick rates are chosen so that tap phases rarely line up. A monitor measures every high and low run on all six outputs over the whole test. Aliasing is checked by writing 0x80 while a divider is set to 127: any decode of only the low address bits would visibly change that output's period.

// File: rtl/clk_xpt_pkg.sv
package clk_xpt_pkg;

   localparam int SEL_W   = 3;
   localparam int NUM_OPT = 1 << SEL_W;
   localparam int NUM_TAP = NUM_OPT - 1;

   typedef enum logic [SEL_W-1:0] {
      SEL_REF     = 3'd0,
      SEL_DIV1    = 3'd1,
      SEL_HALF_A  = 3'd2,
      SEL_HALF_B  = 3'd3,
      SEL_THIRD   = 3'd4,
      SEL_QUARTER = 3'd5,
      SEL_DIV2    = 3'd6,
      SEL_OFF     = 3'd7
   } route_sel_e;

   // Fixed divisor of each tap; 0 marks a programmable tap.
   function automatic int tap_fixed_div(input int k);
      case (k)
         SEL_REF:     return 1;
         SEL_HALF_A:  return 2;
         SEL_HALF_B:  return 2;
         SEL_THIRD:   return 3;
         SEL_QUARTER: return 4;
         default:     return 0;
      endcase
   endfunction

endpackage

// File: rtl/clk_xpt_regs.sv
module clk_xpt_regs #(
   parameter int NUM_OUT = 6,
   parameter int DIV_W   = 7,
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 8,
   parameter int A_DIV1  = 0,
   parameter int A_DIV2  = 1,
   parameter int A_FIX   = 2,
   parameter int A_SEL0  = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [ADDR_W-1:0]                 wr_addr,
   input  logic [DATA_W-1:0]                 wr_data,
   output logic                              div1_src,
   output logic [DIV_W-1:0]                  div1_n,
   output logic                              div2_src,
   output logic [DIV_W-1:0]                  div2_n,
   output logic                              fix_src,
   output logic [NUM_OUT*clk_xpt_pkg::SEL_W-1:0] sel_flat
);
   import clk_xpt_pkg::*;

   logic unused_hi;
   if (DATA_W > DIV_W + 1) begin : g_wide
      assign unused_hi = ^wr_data[DATA_W-1:DIV_W+1];
   end else begin : g_fit
      assign unused_hi = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div1_src <= 1'b0;
         div1_n   <= DIV_W'(1);
         div2_src <= 1'b0;
         div2_n   <= DIV_W'(1);
         fix_src  <= 1'b0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_W'(A_DIV1)) begin
            div1_src <= wr_data[DIV_W];
            div1_n   <= wr_data[DIV_W-1:0];
         end
         if (wr_addr == ADDR_W'(A_DIV2)) begin
            div2_src <= wr_data[DIV_W];
            div2_n   <= wr_data[DIV_W-1:0];
         end
         if (wr_addr == ADDR_W'(A_FIX)) begin
            fix_src <= wr_data[0];
         end
      end
   end

   for (genvar i = 0; i < NUM_OUT; i++) begin : g_sel
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sel_flat[i*SEL_W +: SEL_W] <= SEL_REF;
         end else if (wr_en && wr_addr == ADDR_W'(A_SEL0 + i)) begin
            sel_flat[i*SEL_W +: SEL_W] <= wr_data[SEL_W-1:0];
         end
      end
   end

endmodule

// File: rtl/clk_xpt_tap.sv
module clk_xpt_tap #(
   parameter int CNT_W     = 7,
   parameter int FIXED_DIV = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_ref,
   input  logic             tick_vco,
   input  logic             src_req,
   input  logic [CNT_W-1:0] div_req,
   output logic             lvl,
   output logic             fall
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] div_act_q;
   logic [CNT_W-1:0] eff_req;
   logic             src_act_q;
   logic             tick;
   logic             wrap;

   if (FIXED_DIV >= (1 << CNT_W)) begin : g_bad_div
      $error("clk_xpt_tap: FIXED_DIV does not fit the counter");
   end

   if (FIXED_DIV > 0) begin : g_fixed
      logic unused_div;
      assign unused_div = ^div_req;
      assign eff_req    = CNT_W'(FIXED_DIV);
   end else begin : g_prog
      assign eff_req = (div_req < CNT_W'(2)) ? CNT_W'(1) : div_req;
   end

   assign tick = src_act_q ? tick_vco : tick_ref;
   assign wrap = (cnt_q == div_act_q - CNT_W'(1));
   assign fall = tick & wrap & lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         lvl       <= 1'b0;
         div_act_q <= CNT_W'(1);
         src_act_q <= 1'b0;
      end else begin
         if (tick) begin
            if (wrap) begin
               cnt_q <= '0;
               lvl   <= ~lvl;
            end else begin
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end
         if (fall) begin
            src_act_q <= src_req;
            div_act_q <= eff_req;
         end
      end
   end

endmodule

// File: rtl/clk_xpt_route.sv
module clk_xpt_route
   import clk_xpt_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SEL_W-1:0]   sel_req,
   input  logic [NUM_OPT-1:0] opt_lvl,
   input  logic [NUM_OPT-1:0] opt_fall,
   output logic               clk_o,
   output logic               parked_o,
   output logic [SEL_W-1:0]   act_o
);

   logic [SEL_W-1:0] target_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_o    <= 1'b0;
         parked_o <= 1'b0;
         act_o    <= SEL_REF;
         target_q <= SEL_REF;
      end else begin
         clk_o <= parked_o ? 1'b0 : opt_lvl[act_o];
         if (!parked_o) begin
            if (sel_req != act_o && opt_fall[act_o]) begin
               parked_o <= 1'b1;
               target_q <= sel_req;
            end
         end else if (opt_fall[target_q]) begin
            act_o    <= target_q;
            parked_o <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/clk_xpt_div.sv
module clk_xpt_div #(
   parameter int NUM_OUT = 6,
   parameter int DIV_W   = 7,
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 8,
   parameter int A_DIV1  = 0,
   parameter int A_DIV2  = 1,
   parameter int A_FIX   = 2,
   parameter int A_SEL0  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ref_tick,
   input  logic               vco_tick,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [NUM_OUT-1:0] clk_out
);
   import clk_xpt_pkg::*;

   if (DATA_W < DIV_W + 1) begin : g_bad_data
      $error("clk_xpt_div: data word too narrow for source bit plus divisor");
   end
   if (NUM_OUT < 1 || A_SEL0 + NUM_OUT > (1 << ADDR_W)) begin : g_bad_map
      $error("clk_xpt_div: selector block does not fit the address space");
   end

   logic                       div1_src, div2_src, fix_src;
   logic [DIV_W-1:0]           div1_n, div2_n;
   logic [NUM_OUT*SEL_W-1:0]   sel_flat;
   logic [NUM_OPT-1:0]         opt_lvl;
   logic [NUM_OPT-1:0]         opt_fall;
   logic [NUM_OUT-1:0]         parked_vec;
   logic [NUM_OUT*SEL_W-1:0]   act_flat;

   clk_xpt_regs #(
      .NUM_OUT(NUM_OUT), .DIV_W(DIV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .A_DIV1(A_DIV1), .A_DIV2(A_DIV2), .A_FIX(A_FIX), .A_SEL0(A_SEL0)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .div1_src(div1_src), .div1_n(div1_n),
      .div2_src(div2_src), .div2_n(div2_n), .fix_src(fix_src),
      .sel_flat(sel_flat)
   );

   for (genvar k = 0; k < NUM_TAP; k++) begin : g_tap
      localparam int FD = tap_fixed_div(k);
      logic             src_k;
      logic [DIV_W-1:0] div_k;
      assign src_k = (k == SEL_DIV1) ? div1_src :
                     (k == SEL_DIV2) ? div2_src :
                     (k == SEL_REF)  ? 1'b0     : fix_src;
      assign div_k = (k == SEL_DIV1) ? div1_n :
                     (k == SEL_DIV2) ? div2_n : '0;
      clk_xpt_tap #(.CNT_W(DIV_W), .FIXED_DIV(FD)) u_tap (
         .clk(clk), .rst_n(rst_n), .tick_ref(ref_tick), .tick_vco(vco_tick),
         .src_req(src_k), .div_req(div_k), .lvl(opt_lvl[k]), .fall(opt_fall[k])
      );
   end

   assign opt_lvl[SEL_OFF]  = 1'b0;
   assign opt_fall[SEL_OFF] = 1'b1;

   for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
      clk_xpt_route u_route (
         .clk(clk), .rst_n(rst_n), .sel_req(sel_flat[i*SEL_W +: SEL_W]),
         .opt_lvl(opt_lvl), .opt_fall(opt_fall), .clk_o(clk_out[i]),
         .parked_o(parked_vec[i]), .act_o(act_flat[i*SEL_W +: SEL_W])
      );
   end

endmodule

// File: rtl/clk_xpt_div_chk.sv
module clk_xpt_div_chk #(
   parameter int NUM_OUT = 6,
   parameter int DIV_W   = 7,
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 8,
   parameter int A_DIV1  = 0,
   parameter int A_DIV2  = 1,
   parameter int A_FIX   = 2,
   parameter int A_SEL0  = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     wr_en,
   input logic [ADDR_W-1:0]        wr_addr,
   input logic [DATA_W-1:0]        wr_data,
   input logic [NUM_OUT-1:0]       clk_out,
   input logic [DIV_W:0]           div1_cfg,
   input logic [DIV_W:0]           div2_cfg,
   input logic                     fix_src,
   input logic [NUM_OUT*3-1:0]     sel_flat,
   input logic [NUM_OUT-1:0]       parked_vec,
   input logic [NUM_OUT*3-1:0]     act_flat
);

   logic mapped;
   assign mapped = (wr_addr == ADDR_W'(A_DIV1)) || (wr_addr == ADDR_W'(A_DIV2)) ||
                   (wr_addr == ADDR_W'(A_FIX)) ||
                   (int'(wr_addr) >= A_SEL0 && int'(wr_addr) < A_SEL0 + NUM_OUT);

   // R9
   div1_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(A_DIV1)) |=> div1_cfg == $past(wr_data[DIV_W:0]));

   // R10
   unmapped_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !mapped) |=> ($stable(div1_cfg) && $stable(div2_cfg) &&
                              $stable(fix_src) && $stable(sel_flat)));

   for (genvar i = 0; i < NUM_OUT; i++) begin : g_out_chk
      // R8
      parked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         parked_vec[i] |=> !clk_out[i]);

      // R5
      off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (act_flat[i*3 +: 3] == 3'd7 && !parked_vec[i]) |=> !clk_out[i]);
   end

endmodule

bind clk_xpt_div clk_xpt_div_chk #(
   .NUM_OUT(NUM_OUT), .DIV_W(DIV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
   .A_DIV1(A_DIV1), .A_DIV2(A_DIV2), .A_FIX(A_FIX), .A_SEL0(A_SEL0)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .clk_out(clk_out), .div1_cfg({div1_src, div1_n}), .div2_cfg({div2_src, div2_n}),
   .fix_src(fix_src), .sel_flat(sel_flat), .parked_vec(parked_vec), .act_flat(act_flat)
);

// File: tb/sim_clk_xpt_div.sv
module sim_clk_xpt_div;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_tick = 1'b0;
   logic       vco_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [5:0] clk_out;

   int  errors = 0;
   int  checks = 0;
   int  runts  = 0;
   bit  mon_en = 1'b0;

   always #4 clk = ~clk;

   clk_xpt_div u0 (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .vco_tick(vco_tick),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .clk_out(clk_out)
   );

   // Reference edge every 5 cycles, VCO edge every 2 cycles.
   initial begin : tick_gen
      int rc;
      int vc;
      rc = 0;
      vc = 0;
      forever begin
         @(negedge clk);
         rc = (rc == 4) ? 0 : rc + 1;
         vc = (vc == 1) ? 0 : vc + 1;
         ref_tick = (rc == 0);
         vco_tick = (vc == 0);
      end
   end

   // Run-length monitor: any phase shorter than 2 cycles is a runt (R8).
   initial begin : runt_mon
      int run [6];
      logic [5:0] prev;
      prev = '0;
      for (int o = 0; o < 6; o++) run[o] = 2;
      forever begin
         @(negedge clk);
         for (int o = 0; o < 6; o++) begin
            if (!mon_en) run[o] = 2;
            else if (clk_out[o] != prev[o]) begin
               if (run[o] < 2) runts++;
               run[o] = 1;
            end else run[o]++;
         end
         prev = clk_out;
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic measure(input int o, output int per, output int hi);
      int lo;
      int t;
      per = -1;
      hi = -1;
      t = 0;
      while (clk_out[o] !== 1'b0 && t < 4000) begin @(negedge clk); t++; end
      while (clk_out[o] !== 1'b1 && t < 8000) begin @(negedge clk); t++; end
      if (t >= 8000) return;
      hi = 0;
      while (clk_out[o] === 1'b1 && hi < 4000) begin @(negedge clk); hi++; end
      lo = 0;
      while (clk_out[o] === 1'b0 && lo < 4000) begin @(negedge clk); lo++; end
      per = hi + lo;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // {addr, data, output index, expected period in clk cycles}
   localparam logic [39:0] VEC [0:13] = '{
      {8'h08, 8'h02, 8'd0, 16'd20},   // R3 R9 out0 first /2 of reference
      {8'h09, 8'h03, 8'd1, 16'd20},   // R3 out1 second /2
      {8'h0A, 8'h04, 8'd2, 16'd30},   // R3 out2 /3
      {8'h0B, 8'h05, 8'd3, 16'd40},   // R3 out3 /4
      {8'h02, 8'h01, 8'd2, 16'd12},   // R4 fixed bank now from VCO
      {8'h0C, 8'h01, 8'd4, 16'd10},   // R7 DIV1 at reset value 1
      {8'h00, 8'h07, 8'd4, 16'd70},   // R6 DIV1 = 7 from reference
      {8'h00, 8'h84, 8'd4, 16'd16},   // R6 DIV1 = 4 from VCO
      {8'h0D, 8'h06, 8'd5, 16'd10},   // R7 DIV2 at reset value 1
      {8'h01, 8'h85, 8'd5, 16'd20},   // R6 DIV2 = 5 from VCO
      {8'h01, 8'h00, 8'd5, 16'd10},   // R7 DIV2 = 0 passes reference
      {8'h00, 8'h7F, 8'd4, 16'd1270}, // R6 DIV1 = 127 from reference
      {8'h0B, 8'h00, 8'd3, 16'd10},   // R2 out3 back to bypass
      {8'h0B, 8'h05, 8'd3, 16'd16}    // R4 out3 /4 of VCO
   };

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finished");
      finish_run();
   end

   initial begin : main
      int per;
      int hi;
      repeat (3) @(negedge clk);
      check("R1", "outputs during reset", int'(clk_out), 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      mon_en = 1'b1;

      for (int o = 0; o < 6; o++) begin
         measure(o, per, hi);
         check("R1", $sformatf("out%0d bypass period", o), per, 10);
         check("R2", $sformatf("out%0d bypass high", o), hi, 5);
      end

      for (int v = 0; v < 14; v++) begin
         write_reg(VEC[v][39:32], VEC[v][31:24]);
         repeat (3000) @(negedge clk);
         measure(int'(VEC[v][23:16]), per, hi);
         check("R3/R4/R6/R7", $sformatf("vector %0d period", v), per, int'(VEC[v][15:0]));
         check("R3/R4/R6/R7", $sformatf("vector %0d high", v), hi, int'(VEC[v][15:0]) / 2);
      end

      // R10: alias of the DIV1 address and a selector slot past the last output
      write_reg(8'h80, 8'h02);
      write_reg(8'h0E, 8'h07);
      repeat (3000) @(negedge clk);
      measure(4, per, hi);
      check("R10", "out4 period after unmapped writes", per, 1270);

      // R5: code 7 parks the output low
      write_reg(8'h0A, 8'h07);
      repeat (300) @(negedge clk);
      begin
         int highs;
         highs = 0;
         for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (clk_out[2]) highs++;
         end
         check("R5", "out2 high cycles with code 7", highs, 0);
      end

      check("R8", "runt phases seen", runts, 0);

      // R1: reset in the middle of operation
      mon_en = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1", "outputs during mid-run reset", int'(clk_out), 0);
      rst_n = 1'b1;
      repeat (100) @(negedge clk);
      measure(4, per, hi);
      check("R1", "out4 back to bypass", per, 10);
      measure(2, per, hi);
      check("R1", "out2 back to bypass", per, 10);

      finish_run();
   end

endmodule